// File: doc/BRIEF.md
# Peripheral Protection Permission Selector

This block holds the security and privilege configuration for a group of peripheral protection controllers and turns it into per-port attribute lines. Every controller keeps three port masks: a security mask that marks ports as non-secure, a privilege mask for ports left secure, and a second privilege mask for ports marked non-secure. For each port the block drives a non-secure attribute equal to that port's security bit. It also drives an access-privilege flag taken from whichever of the two privilege masks applies to the port's current security state.

There are ten controllers. Indexes 0 and 1 are the internal APB controllers, with 7 and 3 ports by default. Indexes 2 to 5 are the APB expansion controllers and indexes 6 to 9 are the AHB expansion controllers, with 16 ports each. A register file in front of the block sends decoded write strobes. The secure bank writes the security mask or the secure-privilege mask. The non-secure bank writes only the non-secure-privilege mask. One readback port returns all three masks of a selected controller.

Top module: `ppc_perm_sel`

## Requirements
- R1: After synchronous reset, every mask of every controller is zero, so `nonsec_o`, `ap_o`, `rd_ns`, `rd_sp` and `rd_nsp` all read zero.
- R2: Bit `c*MAXP+i` of `nonsec_o` equals bit i of the security mask of controller c.
- R3: Bit `c*MAXP+i` of `ap_o` equals bit i of the non-secure-privilege mask when security bit i is 1, and bit i of the secure-privilege mask when it is 0.
- R4: A write stores only the low N data bits, where N is the controller's port count (7 for index 0, 3 for index 1, 16 otherwise). Higher bits read back as zero and drive zero on both outputs.
- R5: A secure-bank write with `s_wr_field`=0 replaces the security mask. With `s_wr_field`=1 it replaces the secure-privilege mask. A non-secure-bank write replaces only the non-secure-privilege mask.
- R6: A write to one controller leaves the masks and outputs of every other controller unchanged.
- R7: A write to a controller index of 10 or more has no effect, and reading such an index returns zero.
- R8: A write takes effect on the capturing clock edge. `nonsec_o` and `ap_o` change on the following edge. The readback registers sample the masks held before each edge.
- R9: A secure-bank write and a non-secure-bank write to the same controller in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_wr_en | input | 1 | Secure-bank write strobe |
| s_wr_field | input | 1 | 0 = security mask, 1 = secure-privilege mask |
| s_wr_ctrl | input | CW | Controller index for the secure write |
| s_wr_data | input | MAXP | Secure write data |
| n_wr_en | input | 1 | Non-secure-bank write strobe |
| n_wr_ctrl | input | CW | Controller index for the non-secure write |
| n_wr_data | input | MAXP | Non-secure-privilege write data |
| rd_ctrl | input | CW | Controller index for readback |
| rd_ns | output | MAXP | Registered security mask readback |
| rd_sp | output | MAXP | Registered secure-privilege mask readback |
| rd_nsp | output | MAXP | Registered non-secure-privilege mask readback |
| nonsec_o | output | NCTRL*MAXP | Per-port non-secure attribute, controller c at bits c*MAXP upward |
| ap_o | output | NCTRL*MAXP | Per-port access-privilege flag, same layout |

## Verification
The assertions assume that reset is held for at least one edge before any strobe is sampled. They also assume that strobes and indexes are steady around each rising edge. The bench drives all inputs only on falling edges and starts writing only after releasing reset. The bench's random writes span the full 4-bit index range, so unused indexes are exercised too. The checks compare against a model that updates once per rising edge, and the model assumes the two write banks never target the same mask. This holds by construction, because the two banks write different fields.

// File: rtl/ppc_perm_pkg.sv
package ppc_perm_pkg;

  typedef enum logic {
    FLD_SEC  = 1'b0,
    FLD_SPRV = 1'b1
  } sec_field_e;

  // Port count of controller idx: two internal slots, then expansion slots.
  function automatic int port_count(input int idx, input int p_int0,
                                    input int p_int1, input int p_exp);
    if (idx == 0) return p_int0;
    if (idx == 1) return p_int1;
    return p_exp;
  endfunction

endpackage

// File: rtl/ppc_mask_bank.sv
module ppc_mask_bank
  import ppc_perm_pkg::*;
#(
  parameter int MAXP = 16,
  parameter int NP   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_we,
  input  sec_field_e      s_field,
  input  logic [MAXP-1:0] s_data,
  input  logic            n_we,
  input  logic [MAXP-1:0] n_data,
  output logic [MAXP-1:0] ns_q,
  output logic [MAXP-1:0] sp_q,
  output logic [MAXP-1:0] nsp_q
);
  localparam logic [MAXP-1:0] PMASK = {MAXP{1'b1}} >> (MAXP - NP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else begin
      if (s_we && s_field == FLD_SEC)  ns_q  <= s_data & PMASK;
      if (s_we && s_field == FLD_SPRV) sp_q  <= s_data & PMASK;
      if (n_we)                        nsp_q <= n_data & PMASK;
    end
  end
endmodule

// File: rtl/ppc_port_select.sv
module ppc_port_select #(
  parameter int MAXP = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MAXP-1:0] ns,
  input  logic [MAXP-1:0] sp,
  input  logic [MAXP-1:0] nsp,
  output logic [MAXP-1:0] nonsec_q,
  output logic [MAXP-1:0] ap_q
);
  for (genvar i = 0; i < MAXP; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        nonsec_q[i] <= 1'b0;
        ap_q[i]     <= 1'b0;
      end else begin
        nonsec_q[i] <= ns[i];
        ap_q[i]     <= ns[i] ? nsp[i] : sp[i];
      end
    end
  end
endmodule

// File: rtl/ppc_readback.sv
module ppc_readback #(
  parameter int MAXP  = 16,
  parameter int NCTRL = 10,
  parameter int CW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CW-1:0]         sel,
  input  logic [NCTRL*MAXP-1:0] ns_all,
  input  logic [NCTRL*MAXP-1:0] sp_all,
  input  logic [NCTRL*MAXP-1:0] nsp_all,
  output logic [MAXP-1:0]       rd_ns,
  output logic [MAXP-1:0]       rd_sp,
  output logic [MAXP-1:0]       rd_nsp
);
  logic [MAXP-1:0] ns_m, sp_m, nsp_m;

  always_comb begin
    ns_m  = '0;
    sp_m  = '0;
    nsp_m = '0;
    for (int c = 0; c < NCTRL; c++) begin
      if (sel == CW'(c)) begin
        ns_m  = ns_all[c*MAXP +: MAXP];
        sp_m  = sp_all[c*MAXP +: MAXP];
        nsp_m = nsp_all[c*MAXP +: MAXP];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ns  <= '0;
      rd_sp  <= '0;
      rd_nsp <= '0;
    end else begin
      rd_ns  <= ns_m;
      rd_sp  <= sp_m;
      rd_nsp <= nsp_m;
    end
  end
endmodule

// File: rtl/ppc_perm_sel.sv
module ppc_perm_sel
  import ppc_perm_pkg::*;
#(
  parameter int MAXP      = 16,
  parameter int P_INT0    = 7,
  parameter int P_INT1    = 3,
  parameter int P_EXP     = 16,
  parameter int N_APB_EXP = 4,
  parameter int N_AHB_EXP = 4,
  localparam int NCTRL    = 2 + N_APB_EXP + N_AHB_EXP,
  localparam int CW       = $clog2(NCTRL)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  s_wr_en,
  input  logic                  s_wr_field,
  input  logic [CW-1:0]         s_wr_ctrl,
  input  logic [MAXP-1:0]       s_wr_data,
  input  logic                  n_wr_en,
  input  logic [CW-1:0]         n_wr_ctrl,
  input  logic [MAXP-1:0]       n_wr_data,
  input  logic [CW-1:0]         rd_ctrl,
  output logic [MAXP-1:0]       rd_ns,
  output logic [MAXP-1:0]       rd_sp,
  output logic [MAXP-1:0]       rd_nsp,
  output logic [NCTRL*MAXP-1:0] nonsec_o,
  output logic [NCTRL*MAXP-1:0] ap_o
);
  logic [NCTRL*MAXP-1:0] ns_all, sp_all, nsp_all;
  logic [NCTRL-1:0]      s_hit, n_hit;
  sec_field_e            s_field;

  assign s_field = sec_field_e'(s_wr_field);

  for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
    localparam int NP = port_count(c, P_INT0, P_INT1, P_EXP);

    assign s_hit[c] = s_wr_en && (s_wr_ctrl == CW'(c));
    assign n_hit[c] = n_wr_en && (n_wr_ctrl == CW'(c));

    ppc_mask_bank #(.MAXP(MAXP), .NP(NP)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .s_we   (s_hit[c]),
      .s_field(s_field),
      .s_data (s_wr_data),
      .n_we   (n_hit[c]),
      .n_data (n_wr_data),
      .ns_q   (ns_all[c*MAXP +: MAXP]),
      .sp_q   (sp_all[c*MAXP +: MAXP]),
      .nsp_q  (nsp_all[c*MAXP +: MAXP])
    );

    ppc_port_select #(.MAXP(MAXP)) u_sel (
      .clk     (clk),
      .rst     (rst),
      .ns      (ns_all[c*MAXP +: MAXP]),
      .sp      (sp_all[c*MAXP +: MAXP]),
      .nsp     (nsp_all[c*MAXP +: MAXP]),
      .nonsec_q(nonsec_o[c*MAXP +: MAXP]),
      .ap_q    (ap_o[c*MAXP +: MAXP])
    );
  end

  ppc_readback #(.MAXP(MAXP), .NCTRL(NCTRL), .CW(CW)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .sel    (rd_ctrl),
    .ns_all (ns_all),
    .sp_all (sp_all),
    .nsp_all(nsp_all),
    .rd_ns  (rd_ns),
    .rd_sp  (rd_sp),
    .rd_nsp (rd_nsp)
  );
endmodule

// File: rtl/ppc_perm_sel_chk.sv
module ppc_perm_sel_chk
  import ppc_perm_pkg::*;
#(
  parameter int MAXP   = 16,
  parameter int P_INT0 = 7,
  parameter int P_INT1 = 3,
  parameter int P_EXP  = 16,
  parameter int NCTRL  = 10,
  parameter int CW     = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  s_wr_en,
  input logic [CW-1:0]         s_wr_ctrl,
  input logic                  n_wr_en,
  input logic [MAXP-1:0]       rd_ns,
  input logic [MAXP-1:0]       rd_sp,
  input logic [MAXP-1:0]       rd_nsp,
  input logic [NCTRL*MAXP-1:0] ns_all,
  input logic [NCTRL*MAXP-1:0] sp_all,
  input logic [NCTRL*MAXP-1:0] nsp_all,
  input logic [NCTRL*MAXP-1:0] nonsec_o,
  input logic [NCTRL*MAXP-1:0] ap_o
);
  logic [NCTRL*MAXP-1:0] valid_bits;
  for (genvar c = 0; c < NCTRL; c++) begin : g_vb
    assign valid_bits[c*MAXP +: MAXP] =
      {MAXP{1'b1}} >> (MAXP - port_count(c, P_INT0, P_INT1, P_EXP));
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (nonsec_o == '0 && ap_o == '0 && rd_ns == '0 &&
                    rd_sp == '0 && rd_nsp == '0));

  // R2
  nonsec_follows_chk: assert property (@(posedge clk) disable iff (rst)
    nonsec_o == $past(ns_all));

  // R3
  ap_select_chk: assert property (@(posedge clk) disable iff (rst)
    ap_o == $past((ns_all & nsp_all) | (~ns_all & sp_all)));

  // R4
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((ns_all | sp_all | nsp_all) & ~valid_bits) == '0);

  // R5
  nsbank_only_nsp_chk: assert property (@(posedge clk) disable iff (rst)
    !s_wr_en |=> ($stable(ns_all) && $stable(sp_all)));

  // R5
  sbank_keeps_nsp_chk: assert property (@(posedge clk) disable iff (rst)
    !n_wr_en |=> $stable(nsp_all));

  // R7
  bad_index_chk: assert property (@(posedge clk) disable iff (rst)
    (s_wr_en && int'(s_wr_ctrl) >= NCTRL) |=> ($stable(ns_all) && $stable(sp_all)));
endmodule

bind ppc_perm_sel ppc_perm_sel_chk #(
  .MAXP(MAXP), .P_INT0(P_INT0), .P_INT1(P_INT1), .P_EXP(P_EXP),
  .NCTRL(NCTRL), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s_wr_en  (s_wr_en),
  .s_wr_ctrl(s_wr_ctrl),
  .n_wr_en  (n_wr_en),
  .rd_ns    (rd_ns),
  .rd_sp    (rd_sp),
  .rd_nsp   (rd_nsp),
  .ns_all   (ns_all),
  .sp_all   (sp_all),
  .nsp_all  (nsp_all),
  .nonsec_o (nonsec_o),
  .ap_o     (ap_o)
);

// File: tb/ppc_perm_sel_test.sv
module ppc_perm_sel_test;
  localparam int MAXP = 16;
  localparam int NC   = 10;
  localparam int CW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            s_wr_en = 1'b0, s_wr_field = 1'b0;
  logic [CW-1:0]   s_wr_ctrl = '0, n_wr_ctrl = '0, rd_ctrl = '0;
  logic [MAXP-1:0] s_wr_data = '0, n_wr_data = '0;
  logic            n_wr_en = 1'b0;
  logic [MAXP-1:0] rd_ns, rd_sp, rd_nsp;
  logic [NC*MAXP-1:0] nonsec_o, ap_o;

  int tests = 0, fails = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  ppc_perm_sel uut (
    .clk(clk), .rst(rst),
    .s_wr_en(s_wr_en), .s_wr_field(s_wr_field), .s_wr_ctrl(s_wr_ctrl),
    .s_wr_data(s_wr_data),
    .n_wr_en(n_wr_en), .n_wr_ctrl(n_wr_ctrl), .n_wr_data(n_wr_data),
    .rd_ctrl(rd_ctrl),
    .rd_ns(rd_ns), .rd_sp(rd_sp), .rd_nsp(rd_nsp),
    .nonsec_o(nonsec_o), .ap_o(ap_o)
  );

  // Behavioural reference: masks per controller, expected registered outputs.
  int m_ns[NC], m_sp[NC], m_nsp[NC];
  int e_nonsec[NC], e_ap[NC];
  int e_rns, e_rsp, e_rnsp;

  function automatic int ports_of(input int c);
    return (c == 0) ? 7 : (c == 1) ? 3 : 16;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NC; c++) begin
        m_ns[c] = 0; m_sp[c] = 0; m_nsp[c] = 0; e_nonsec[c] = 0; e_ap[c] = 0;
      end
      e_rns = 0; e_rsp = 0; e_rnsp = 0;
    end else begin
      int r;
      r = int'(rd_ctrl);
      e_rns  = (r < NC) ? m_ns[r]  : 0;
      e_rsp  = (r < NC) ? m_sp[r]  : 0;
      e_rnsp = (r < NC) ? m_nsp[r] : 0;
      for (int c = 0; c < NC; c++) begin
        e_nonsec[c] = m_ns[c];
        e_ap[c]     = (m_ns[c] & m_nsp[c]) | (~m_ns[c] & m_sp[c] & 32'hFFFF);
      end
      if (s_wr_en && int'(s_wr_ctrl) < NC) begin
        int lim;
        lim = (1 << ports_of(int'(s_wr_ctrl))) - 1;
        if (!s_wr_field) m_ns[s_wr_ctrl] = int'(s_wr_data) & lim;
        else             m_sp[s_wr_ctrl] = int'(s_wr_data) & lim;
      end
      if (n_wr_en && int'(n_wr_ctrl) < NC)
        m_nsp[n_wr_ctrl] = int'(n_wr_data) & ((1 << ports_of(int'(n_wr_ctrl))) - 1);
    end
  end

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (model_on && !rst) begin
      for (int c = 0; c < NC; c++) begin
        check("R2", int'(nonsec_o[c*MAXP +: MAXP]), e_nonsec[c]);
        check("R3", int'(ap_o[c*MAXP +: MAXP]), e_ap[c]);
      end
      check("R5", int'(rd_ns), e_rns);
      check("R5", int'(rd_sp), e_rsp);
      check("R5", int'(rd_nsp), e_rnsp);
    end
  end

  task automatic swr(input int c, input bit fld, input int d);
    @(negedge clk);
    s_wr_en = 1'b1; s_wr_field = fld; s_wr_ctrl = CW'(c); s_wr_data = MAXP'(d);
    @(negedge clk);
    s_wr_en = 1'b0;
  endtask

  task automatic nwr(input int c, input int d);
    @(negedge clk);
    n_wr_en = 1'b1; n_wr_ctrl = CW'(c); n_wr_data = MAXP'(d);
    @(negedge clk);
    n_wr_en = 1'b0;
  endtask

  task automatic settle(input int c);
    rd_ctrl = CW'(c);
    repeat (2) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    logic [NC*MAXP-1:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(nonsec_o == '0 && ap_o == '0), 1);
    check("R1", int'(rd_ns | rd_sp | rd_nsp), 0);
    model_on = 1'b1;

    // R8 latency: write captured at one edge, outputs follow one edge later
    rd_ctrl = 4'd2;
    @(negedge clk);
    s_wr_en = 1'b1; s_wr_field = 1'b0; s_wr_ctrl = 4'd2; s_wr_data = 16'h00F0;
    @(negedge clk);
    s_wr_en = 1'b0;
    check("R8", int'(nonsec_o[2*MAXP +: MAXP]), 0);
    check("R8", int'(rd_ns), 0);
    @(negedge clk);
    check("R8", int'(nonsec_o[2*MAXP +: MAXP]), 16'h00F0);
    check("R8", int'(rd_ns), 16'h00F0);

    // R4 port-count masking
    swr(0, 1'b0, 16'hFFFF); settle(0);
    check("R4", int'(rd_ns), 16'h007F);
    swr(1, 1'b1, 16'hFFFF); nwr(1, 16'hFFFF); settle(1);
    check("R4", int'(rd_sp), 16'h0007);
    check("R4", int'(rd_nsp), 16'h0007);
    check("R4", int'(ap_o[1*MAXP +: MAXP]), 16'h0007);

    // R3 mixed selection on controller 6
    swr(6, 1'b0, 16'h00FF); swr(6, 1'b1, 16'h0F0F); nwr(6, 16'h3333); settle(6);
    check("R3", int'(ap_o[6*MAXP +: MAXP]), 16'h0F33);
    check("R5", int'(rd_nsp), 16'h3333);

    // R9 simultaneous banks on controller 9
    @(negedge clk);
    s_wr_en = 1'b1; s_wr_field = 1'b0; s_wr_ctrl = 4'd9; s_wr_data = 16'hAAAA;
    n_wr_en = 1'b1; n_wr_ctrl = 4'd9; n_wr_data = 16'h5555;
    @(negedge clk);
    s_wr_en = 1'b0; n_wr_en = 1'b0;
    settle(9);
    check("R9", int'(rd_ns), 16'hAAAA);
    check("R9", int'(rd_nsp), 16'h5555);
    check("R9", int'(ap_o[9*MAXP +: MAXP]), 0);
    // R6 controller 6 untouched by the controller 9 writes
    check("R6", int'(ap_o[6*MAXP +: MAXP]), 16'h0F33);

    // R7 out-of-range write and read
    snap = nonsec_o;
    swr(12, 1'b0, 16'hFFFF); nwr(13, 16'hFFFF); settle(12);
    check("R7", int'(nonsec_o == snap), 1);
    check("R7", int'(rd_ns | rd_sp | rd_nsp), 0);

    // Random traffic, compared every cycle
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      s_wr_en    = $urandom_range(0, 1) == 1;
      s_wr_field = $urandom_range(0, 1) == 1;
      s_wr_ctrl  = CW'($urandom_range(0, 15));
      s_wr_data  = MAXP'($urandom);
      n_wr_en    = $urandom_range(0, 2) == 0;
      n_wr_ctrl  = CW'($urandom_range(0, 15));
      n_wr_data  = MAXP'($urandom);
      rd_ctrl    = CW'($urandom_range(0, 15));
    end
    @(negedge clk);
    s_wr_en = 1'b0; n_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule